// File: doc/BRIEF.md
# Interconnect Test Vector Generator and Net Fault Diagnoser

This block drives a set of board nets, through a boundary scan chain, with parallel test vectors and then diagnoses what comes back. Each net is given a code word of its own. A test vector is one bit position of all code words taken together. The block drives one such slice at a time, and an external controller moves it on to the next slice with an accept handshake. On the accept cycle the controller also returns the response vector that was captured for the slice just driven.

When the last slice has been accepted, the block has the word each net actually received. It compares that word with the word the net was assigned. Two per-net flag vectors report the result: one for any mismatch and one for an open, which is a net that read zero throughout the test. Shorts follow a wired-AND model and opens a stuck-at-0 model. An optional extra slice, driven as all ones before the code bits, lets a shorted net be told apart from an open one.

Top module: `netcode_diag`

## Requirements
- R1: While reset is applied, and after it is released until the first start, drive_vec, drive_valid, done, fault and open_net are all zero.
- R2: Net i (counting from 0) is assigned the code value i+1, CW = ceil(log2(NUM_NETS+2)) bits wide. No net is ever assigned a code of all zeros or all ones.
- R3: One test contains exactly TL = CW + EXTRA_BIT slices. The cycle after the TL-th accept, done is 1 and drive_valid is 0.
- R4: The test word of a net is {1'b1, code} when EXTRA_BIT=1 and just the code when EXTRA_BIT=0. The word is sent most significant bit first. While slice k is on offer, drive_vec[i] equals bit TL-1-k of net i's word. drive_vec is zero whenever drive_valid is 0.
- R5: resp_vec is sampled on every cycle in which vec_accept is high and a slice is on offer. After done rises, fault[i] is 1 exactly when the word net i received differs from its assigned word.
- R6: After done rises, open_net[i] is 1 exactly when the word net i received is all zeros. A net that is flagged open is also flagged faulty.
- R7: The cycle after start, done, fault and open_net are zero and slice 0 is on offer (drive_valid = 1). fault and open_net stay zero for as long as done is low.
- R8: vec_accept has no effect while no slice is on offer. A start pulse during a test discards the partial result and begins again at slice 0.
- R9: done, fault and open_net hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new test (one-cycle pulse) |
| vec_accept | input | 1 | Current slice applied; resp_vec is valid in this cycle |
| resp_vec | input | NUM_NETS | Captured response for the current slice |
| drive_vec | output | NUM_NETS | Slice to drive onto the nets |
| drive_valid | output | 1 | A slice is on offer |
| done | output | 1 | Test complete; flags are valid |
| fault | output | NUM_NETS | Net received a word other than its own |
| open_net | output | NUM_NETS | Net received the all-zero word |

## Verification
Each slice is checked one cycle after the start pulse or after the accept that advanced to it. A check that falls on the last accept expects done and valid flags one cycle after that accept. Inputs change at the falling edge, and outputs are sampled at the falling edge before anything is driven, so every check reads the state left by exactly one rising edge. The response for each slice is built by the bench from its own copy of the code words, with any wired-AND shorts and stuck-at-0 opens applied. The expected flags come from the words that model would deliver. None of this is read from drive_vec.

// File: rtl/ictd_pkg.sv
package ictd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ictd_state_e;

  // Test word of net idx: code idx+1, optionally headed by a constant 1.
  function automatic int unsigned net_word(input int unsigned idx,
                                           input int unsigned cw,
                                           input bit          extra);
    int unsigned head;
    head = extra ? (32'd1 << cw) : 32'd0;
    return head + idx + 32'd1;
  endfunction

endpackage

// File: rtl/ictd_seq.sv
module ictd_seq #(
  parameter int TL = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          vec_accept,
  output logic [SW-1:0] step,
  output logic          running,
  output logic          finished,
  output logic          clr,
  output logic          shift_en
);
  import ictd_pkg::*;

  ictd_state_e state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          state_en, step_en;
  logic          last_step;

  assign last_step = (step_q == SW'(TL - 1));

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    state_en = 1'b0;
    step_en  = 1'b0;
    if (start) begin
      state_d  = ST_RUN;
      step_d   = '0;
      state_en = 1'b1;
      step_en  = 1'b1;
    end else if (state_q == ST_RUN && vec_accept) begin
      if (last_step) begin
        state_d  = ST_DONE;
        state_en = 1'b1;
      end else begin
        step_d  = step_q + SW'(1);
        step_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign step     = step_q;
  assign running  = (state_q == ST_RUN);
  assign finished = (state_q == ST_DONE);
  assign clr      = start;
  assign shift_en = running & vec_accept & ~start;

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (step_q <= SW'(TL - 1)));

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished) |-> $past(running && vec_accept && last_step));

  // R8
  idle_accept_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(step_q));

  // R7
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && step_q == '0));

endmodule

// File: rtl/ictd_codegen.sv
module ictd_codegen #(
  parameter int NUM_NETS  = 6,
  parameter int CW        = 3,
  parameter int TL        = 4,
  parameter int SW        = 2,
  parameter bit EXTRA_BIT = 1'b1
) (
  input  logic [SW-1:0]       step,
  input  logic                running,
  output logic [NUM_NETS-1:0] slice
);
  import ictd_pkg::*;

  logic [SW-1:0] bit_idx;
  assign bit_idx = SW'(TL - 1) - step;

  for (genvar gi = 0; gi < NUM_NETS; gi++) begin : g_net
    localparam logic [TL-1:0] WORD = TL'(net_word(gi, CW, EXTRA_BIT));
    assign slice[gi] = running & WORD[bit_idx];
  end

  // R4
  always_comb begin
    if (!running) begin
      idle_slice_zero_chk: assert (slice == '0);
    end
  end

endmodule

// File: rtl/ictd_capture.sv
module ictd_capture #(
  parameter int NUM_NETS = 6,
  parameter int TL       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   shift_en,
  input  logic [NUM_NETS-1:0]    resp,
  output logic [NUM_NETS*TL-1:0] rx_words
);

  for (genvar gi = 0; gi < NUM_NETS; gi++) begin : g_net
    logic [TL-1:0] rx_q, rx_d;
    logic          rx_en;

    always_comb begin
      rx_en = clr | shift_en;
      if (clr) begin
        rx_d = '0;
      end else begin
        rx_d = {rx_q[TL-2:0], resp[gi]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_q <= '0;
      end else if (rx_en) begin
        rx_q <= rx_d;
      end
    end

    assign rx_words[gi*TL +: TL] = rx_q;
  end

endmodule

// File: rtl/ictd_diag.sv
module ictd_diag #(
  parameter int NUM_NETS  = 6,
  parameter int CW        = 3,
  parameter int TL        = 4,
  parameter bit EXTRA_BIT = 1'b1
) (
  input  logic                   valid,
  input  logic [NUM_NETS*TL-1:0] rx_words,
  output logic [NUM_NETS-1:0]    fault,
  output logic [NUM_NETS-1:0]    open_net
);
  import ictd_pkg::*;

  for (genvar gi = 0; gi < NUM_NETS; gi++) begin : g_net
    localparam logic [TL-1:0] WORD = TL'(net_word(gi, CW, EXTRA_BIT));
    logic [TL-1:0] rx;
    assign rx           = rx_words[gi*TL +: TL];
    assign fault[gi]    = valid & (rx != WORD);
    assign open_net[gi] = valid & (rx == '0);
  end

endmodule

// File: rtl/netcode_diag.sv
module netcode_diag #(
  parameter int NUM_NETS  = 6,
  parameter bit EXTRA_BIT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                vec_accept,
  input  logic [NUM_NETS-1:0] resp_vec,
  output logic [NUM_NETS-1:0] drive_vec,
  output logic                drive_valid,
  output logic                done,
  output logic [NUM_NETS-1:0] fault,
  output logic [NUM_NETS-1:0] open_net
);
  localparam int CW = $clog2(NUM_NETS + 2);
  localparam int TL = CW + (EXTRA_BIT ? 1 : 0);
  localparam int SW = $clog2(TL);

  if (NUM_NETS < 1 || (NUM_NETS + 1) >= (1 << CW)) begin : g_bad_cfg
    $error("netcode_diag: code space cannot avoid the all-one word");
  end

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic [SW-1:0]          step;
  logic                   running, finished, clr, shift_en;
  logic [NUM_NETS*TL-1:0] rx_words;

  ictd_seq #(.TL(TL), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_i), .start(start), .vec_accept(vec_accept),
    .step(step), .running(running), .finished(finished),
    .clr(clr), .shift_en(shift_en)
  );

  ictd_codegen #(.NUM_NETS(NUM_NETS), .CW(CW), .TL(TL), .SW(SW),
                 .EXTRA_BIT(EXTRA_BIT)) u_gen (
    .step(step), .running(running), .slice(drive_vec)
  );

  ictd_capture #(.NUM_NETS(NUM_NETS), .TL(TL)) u_cap (
    .clk(clk), .rst_n(rst_i), .clr(clr), .shift_en(shift_en),
    .resp(resp_vec), .rx_words(rx_words)
  );

  ictd_diag #(.NUM_NETS(NUM_NETS), .CW(CW), .TL(TL),
              .EXTRA_BIT(EXTRA_BIT)) u_diag (
    .valid(finished), .rx_words(rx_words), .fault(fault), .open_net(open_net)
  );

  assign drive_valid = running;
  assign done        = finished;

  // R6
  open_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ((open_net & ~fault) == '0));

  // R7
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !done |-> (fault == '0 && open_net == '0));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(done) && done) |-> ($stable(fault) && $stable(open_net)));

  // R3
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !(done && drive_valid));

endmodule

// File: tb/sim_netcode_diag.sv
module sim_netcode_diag;
  localparam int N     = 6;
  localparam int CWB   = 3;
  localparam int TLB   = 4;

  logic         clk, rst_n, start, vec_accept;
  logic [N-1:0] resp_vec, drive_vec, fault, open_net;
  logic         drive_valid, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  netcode_diag #(.NUM_NETS(N), .EXTRA_BIT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_accept(vec_accept),
    .resp_vec(resp_vec), .drive_vec(drive_vec), .drive_valid(drive_valid),
    .done(done), .fault(fault), .open_net(open_net)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Word of net i: leading 1, then 3-bit code i+1.
  function automatic logic [TLB-1:0] word_of(input int i);
    return TLB'(8 + i + 1);
  endfunction

  function automatic logic [N-1:0] slice_of(input int k);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = word_of(i)[TLB-1-k];
    return s;
  endfunction

  // Word a net reads under the fault model (opens and one shorted group).
  function automatic logic [TLB-1:0] rx_of(input int i, input logic [N-1:0] om,
                                           input logic [N-1:0] sm);
    logic [TLB-1:0] w;
    if (om[i]) return '0;
    if (!sm[i]) return word_of(i);
    w = '1;
    for (int j = 0; j < N; j++) if (sm[j]) w &= word_of(j);
    return w;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_test(input logic [N-1:0] om_in, input logic [N-1:0] sm_in,
                         input bit gaps);
    logic [N-1:0] om, sm, ef, eo, r;
    om = om_in;
    sm = sm_in & ~om_in;
    pulse_start();
    chk({31'd0, done}, 32'd0, "R7 done clear");
    chk({26'd0, fault}, 32'd0, "R7 fault clear");
    for (int k = 0; k < TLB; k++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int c = 0; c < g; c++) begin @(posedge clk); @(negedge clk); end
      end
      chk({31'd0, drive_valid}, 32'd1, "R3 valid");
      chk({26'd0, drive_vec}, {26'd0, slice_of(k)}, "R4 slice");
      for (int i = 0; i < N; i++) r[i] = rx_of(i, om, sm)[TLB-1-k];
      resp_vec   = r;
      vec_accept = 1'b1;
      @(posedge clk); @(negedge clk);
      vec_accept = 1'b0;
      resp_vec   = $urandom();
    end
    for (int i = 0; i < N; i++) begin
      ef[i] = (rx_of(i, om, sm) != word_of(i));
      eo[i] = (rx_of(i, om, sm) == '0);
    end
    chk({31'd0, done}, 32'd1, "R3 done");
    chk({31'd0, drive_valid}, 32'd0, "R3 valid low");
    chk({26'd0, fault}, {26'd0, ef}, "R5 fault");
    chk({26'd0, open_net}, {26'd0, eo}, "R6 open");
  endtask

  initial begin
    logic [N-1:0] f_snap, o_snap;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; vec_accept = 1'b0; resp_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({26'd0, drive_vec}, 32'd0, "R1 drive");
    chk({31'd0, done}, 32'd0, "R1 done");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({31'd0, drive_valid}, 32'd0, "R1 valid");
    chk({26'd0, fault | open_net}, 32'd0, "R1 flags");

    // R8: accept while idle does nothing
    vec_accept = 1'b1; resp_vec = '1;
    @(posedge clk); @(negedge clk);
    vec_accept = 1'b0;
    chk({31'd0, drive_valid | done}, 32'd0, "R8 idle accept");

    // R2: code words differ, never all zero or all one
    for (int i = 0; i < N; i++) begin
      chk({31'd0, (word_of(i)[CWB-1:0] != '0) && (word_of(i)[CWB-1:0] != '1)},
          32'd1, "R2 code range");
    end

    do_test('0, '0, 1'b0);                 // fault-free
    do_test(6'b000001, '0, 1'b0);          // open on net 0
    do_test('0, 6'b100100, 1'b0);          // short nets 2 and 5
    do_test('0, 6'b111111, 1'b0);          // all nets shorted
    do_test(6'b010000, 6'b000011, 1'b1);   // open plus short

    // R9: flags hold and accept after done is ignored
    f_snap = fault; o_snap = open_net;
    vec_accept = 1'b1; resp_vec = '0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    vec_accept = 1'b0;
    chk({31'd0, done}, 32'd1, "R9 done hold");
    chk({26'd0, fault}, {26'd0, f_snap}, "R9 fault hold");
    chk({26'd0, open_net}, {26'd0, o_snap}, "R8 open hold");

    // R8: restart in the middle of a test
    pulse_start();
    for (int k = 0; k < 2; k++) begin
      resp_vec = '0; vec_accept = 1'b1;
      @(posedge clk); @(negedge clk);
      vec_accept = 1'b0;
    end
    pulse_start();
    chk({26'd0, drive_vec}, {26'd0, slice_of(0)}, "R8 restart slice0");
    chk({31'd0, done}, 32'd0, "R8 restart done");
    do_test('0, '0, 1'b0);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] om, sm;
      om = ($urandom_range(0, 3) == 0) ? N'($urandom()) : '0;
      sm = ($urandom_range(0, 1) == 0) ? N'($urandom()) : '0;
      do_test(om, sm, 1'b1);
    end

    finish_run();
  end

endmodule